// File: doc/BRIEF.md
# Capture Timer Channel

This block is one timer channel that runs in capture mode. A counter of `CNT_W` bits (16 by default) advances once per clock while the channel clock is enabled, the channel is not halted, and the count-enable input is high. Edges on input A copy the counter into two capture registers, A first and then B. Software reads the two values later to measure pulse widths and periods.

A restart sets the counter to zero. It comes from a software strobe, from a selected edge on input A or input B, or, if enabled, from the counter reaching the compare value. An optional setting halts the counter on each B capture, and another turns the channel clock off on each B capture. Eight sticky event flags are reported. A write-only pair of strobes sets and clears bits in a mask, and a single interrupt line reports any flag whose mask bit is set.

Top module: `cap_timer_ch`

## Requirements
- R1: After reset the counter, both capture registers, the flags and the mask are zero, the channel clock is off and `irq_o` is low.
- R2: `clk_en_i` turns the channel clock on and `clk_dis_i` turns it off, with off winning when both are high; `clk_sta_o` shows the state. The counter rises by one on every clock where the channel clock is on, the channel is not halted and `cnt_en_i` is high.
- R3: A counting clock at all-ones wraps the counter to zero and sets flag bit 0.
- R4: A counting clock where the counter equals `rc_val_i` sets flag bit 4. With `rc_trg_en_i` high, that clock restarts the counter, so the next value is zero.
- R5: The restart-edge select applies to input B, or to input A when `trg_src_a_i` is 1, with the encoding 00 none, 01 rising, 10 falling, 11 both. A selected edge zeroes the counter, clears a halt and sets flag bit 7. `sw_trg_i` does the same without setting bit 7. A restart takes priority over counting.
- R6: When no A capture is pending its B capture, an edge on A that matches `ra_edge_i` (same encoding) copies the pre-edge counter into `ra_o` and sets flag bit 5.
- R7: After an A capture, an edge on A that matches `rb_edge_i` copies the counter into `rb_o` and sets flag bit 6. Further edges go back to A captures. If both selects match one edge, the capture in turn takes it.
- R8: Capturing into a register that has not been read since its last capture (`ra_rd_i` or `rb_rd_i` marks it read) sets flag bit 1.
- R9: On a B capture, `stop_on_rb_i` halts the counter until the next restart, and `dis_on_rb_i` turns the channel clock off.
- R10: Flags are sticky, and an `sr_rd_i` strobe clears them. An event in the same clock as the strobe still sets its flag. Bits 2 and 3 always read 0.
- R11: `int_en_i` sets and `int_dis_i` clears the mask bits given in `int_bits_i`, with clear winning. `irq_o` is the OR of the flags ANDed with the mask.
- R12: `mir_a_o` and `mir_b_o` show the levels of inputs A and B sampled at the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable |
| clk_en_i | input | 1 | Channel clock on strobe |
| clk_dis_i | input | 1 | Channel clock off strobe |
| sw_trg_i | input | 1 | Software restart strobe |
| tin_a_i | input | 1 | Input A (capture and optional restart source) |
| tin_b_i | input | 1 | Input B (restart source) |
| ra_edge_i | input | 2 | A capture edge select |
| rb_edge_i | input | 2 | B capture edge select |
| trg_edge_i | input | 2 | Restart edge select |
| trg_src_a_i | input | 1 | 1: restart edge taken from A |
| rc_trg_en_i | input | 1 | Compare match restarts counter |
| stop_on_rb_i | input | 1 | Halt counter on B capture |
| dis_on_rb_i | input | 1 | Clock off on B capture |
| rc_val_i | input | CNT_W | Compare value |
| ra_rd_i | input | 1 | Capture A read strobe |
| rb_rd_i | input | 1 | Capture B read strobe |
| sr_rd_i | input | 1 | Flag read strobe (clears flags) |
| int_en_i | input | 1 | Mask set strobe |
| int_dis_i | input | 1 | Mask clear strobe |
| int_bits_i | input | 8 | Mask bits to set or clear |
| cnt_o | output | CNT_W | Counter value |
| ra_o | output | CNT_W | Capture register A |
| rb_o | output | CNT_W | Capture register B |
| status_o | output | 8 | Sticky flags |
| clk_sta_o | output | 1 | Channel clock state |
| mir_a_o | output | 1 | Sampled level of A |
| mir_b_o | output | 1 | Sampled level of B |
| imr_o | output | 8 | Interrupt mask |
| irq_o | output | 1 | Interrupt request |

## Verification
Each strobe and input edge is applied at a falling clock edge and takes effect at the next rising edge. The counter, the captures, the flags, the mask and the mirrors are all registered, so every one of them is due one clock after its stimulus. `irq_o` is a combinational function of the flag and mask registers, so it follows in the same clock. The bench steps its reference model just after each rising edge and compares every output at the following falling edge. That single-cycle alignment holds for the directed sequences: wrap, compare restart, edge restart, capture order, overrun, halt and mask. It holds equally for the random phases.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int FLAG_W  = 8;
  localparam int FL_OVF  = 0;
  localparam int FL_LOVR = 1;
  localparam int FL_CPA  = 2;
  localparam int FL_CPB  = 3;
  localparam int FL_CPC  = 4;
  localparam int FL_LDA  = 5;
  localparam int FL_LDB  = 6;
  localparam int FL_ETRG = 7;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
    unique case (edge_sel_e'(sel))
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '0;
    else         q <= sig_i;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise_o[i] = sig_i[i] & ~q[i];
    assign fall_o[i] = ~sig_i[i] & q[i];
  end
  assign lvl_o = q;
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             en_cmd_i,
  input  logic             dis_cmd_i,
  input  logic             trg_i,
  input  logic [CNT_W-1:0] rc_val_i,
  input  logic             rc_trg_en_i,
  input  logic             rb_ld_i,
  input  logic             stop_on_rb_i,
  input  logic             dis_on_rb_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             clk_on_o,
  output logic             run_o,
  output logic             ovf_o,
  output logic             cpc_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             on_q, halt_q, restart;

  assign run_o   = on_q & ~halt_q & cnt_en_i;
  assign cpc_o   = run_o & (cnt_q == rc_val_i);
  assign ovf_o   = run_o & (cnt_q == CNT_MAX);
  assign restart = trg_i | (cpc_o & rc_trg_en_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (run_o)   cnt_q <= cnt_q + 1'b1;

  // halt set on B capture wins over a same-cycle restart
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                       halt_q <= 1'b0;
    else if (rb_ld_i && stop_on_rb_i)  halt_q <= 1'b1;
    else if (restart)                  halt_q <= 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                 on_q <= 1'b0;
    else if (dis_cmd_i || (rb_ld_i && dis_on_rb_i)) on_q <= 1'b0;
    else if (en_cmd_i)                           on_q <= 1'b1;

  assign cnt_o    = cnt_q;
  assign clk_on_o = on_q;
endmodule

// File: rtl/cap_capture.sv
module cap_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ra_hit_i,
  input  logic             rb_hit_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ra_rd_i,
  input  logic             rb_rd_i,
  output logic [CNT_W-1:0] ra_o,
  output logic [CNT_W-1:0] rb_o,
  output logic             ra_ld_o,
  output logic             rb_ld_o,
  output logic             lovr_o
);
  logic [CNT_W-1:0] ra_q, rb_q;
  logic             want_b_q, ra_unrd_q, rb_unrd_q;

  assign ra_ld_o = ra_hit_i & ~want_b_q;
  assign rb_ld_o = rb_hit_i &  want_b_q;
  assign lovr_o  = (ra_ld_o & ra_unrd_q) | (rb_ld_o & rb_unrd_q);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ra_q      <= '0;
      rb_q      <= '0;
      want_b_q  <= 1'b0;
      ra_unrd_q <= 1'b0;
      rb_unrd_q <= 1'b0;
    end else begin
      if (ra_ld_o) begin
        ra_q      <= cnt_i;
        ra_unrd_q <= 1'b1;
        want_b_q  <= 1'b1;
      end else if (ra_rd_i) begin
        ra_unrd_q <= 1'b0;
      end
      if (rb_ld_o) begin
        rb_q      <= cnt_i;
        rb_unrd_q <= 1'b1;
        want_b_q  <= 1'b0;
      end else if (rb_rd_i) begin
        rb_unrd_q <= 1'b0;
      end
    end

  assign ra_o = ra_q;
  assign rb_o = rb_q;
endmodule

// File: rtl/cap_irq.sv
module cap_irq
  import cap_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] ev_i,
  input  logic              sr_rd_i,
  input  logic              int_en_i,
  input  logic              int_dis_i,
  input  logic [FLAG_W-1:0] int_bits_i,
  output logic [FLAG_W-1:0] status_o,
  output logic [FLAG_W-1:0] imr_o,
  output logic              irq_o
);
  logic [FLAG_W-1:0] sts_q, imr_q, set_m, clr_m;

  assign set_m = int_en_i  ? int_bits_i : '0;
  assign clr_m = int_dis_i ? int_bits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sts_q <= '0;
      imr_q <= '0;
    end else begin
      sts_q <= (sr_rd_i ? '0 : sts_q) | ev_i;
      imr_q <= (imr_q | set_m) & ~clr_m;
    end

  assign status_o = sts_q;
  assign imr_o    = imr_q;
  assign irq_o    = |(sts_q & imr_q);
endmodule

// File: rtl/cap_timer_ch.sv
module cap_timer_ch
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             clk_en_i,
  input  logic             clk_dis_i,
  input  logic             sw_trg_i,
  input  logic             tin_a_i,
  input  logic             tin_b_i,
  input  logic [1:0]       ra_edge_i,
  input  logic [1:0]       rb_edge_i,
  input  logic [1:0]       trg_edge_i,
  input  logic             trg_src_a_i,
  input  logic             rc_trg_en_i,
  input  logic             stop_on_rb_i,
  input  logic             dis_on_rb_i,
  input  logic [CNT_W-1:0] rc_val_i,
  input  logic             ra_rd_i,
  input  logic             rb_rd_i,
  input  logic             sr_rd_i,
  input  logic             int_en_i,
  input  logic             int_dis_i,
  input  logic [7:0]       int_bits_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ra_o,
  output logic [CNT_W-1:0] rb_o,
  output logic [7:0]       status_o,
  output logic             clk_sta_o,
  output logic             mir_a_o,
  output logic             mir_b_o,
  output logic [7:0]       imr_o,
  output logic             irq_o
);
  localparam int PIN_A = 0;
  localparam int PIN_B = 1;

  logic [1:0]        lvl_w, rise_w, fall_w;
  logic              ra_hit_w, rb_hit_w, ext_trg_w, trg_w;
  logic              run_w, ovf_w, cpc_w, ra_ld_w, rb_ld_w, lovr_w;
  logic [FLAG_W-1:0] ev_w;

  cap_edge_det #(.N(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({tin_b_i, tin_a_i}),
    .lvl_o  (lvl_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  assign ra_hit_w  = edge_hit(ra_edge_i, rise_w[PIN_A], fall_w[PIN_A]);
  assign rb_hit_w  = edge_hit(rb_edge_i, rise_w[PIN_A], fall_w[PIN_A]);
  assign ext_trg_w = trg_src_a_i ? edge_hit(trg_edge_i, rise_w[PIN_A], fall_w[PIN_A])
                                 : edge_hit(trg_edge_i, rise_w[PIN_B], fall_w[PIN_B]);
  assign trg_w     = ext_trg_w | sw_trg_i;

  cap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnt_en_i     (cnt_en_i),
    .en_cmd_i     (clk_en_i),
    .dis_cmd_i    (clk_dis_i),
    .trg_i        (trg_w),
    .rc_val_i     (rc_val_i),
    .rc_trg_en_i  (rc_trg_en_i),
    .rb_ld_i      (rb_ld_w),
    .stop_on_rb_i (stop_on_rb_i),
    .dis_on_rb_i  (dis_on_rb_i),
    .cnt_o        (cnt_o),
    .clk_on_o     (clk_sta_o),
    .run_o        (run_w),
    .ovf_o        (ovf_w),
    .cpc_o        (cpc_w)
  );

  cap_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_hit_i (ra_hit_w),
    .rb_hit_i (rb_hit_w),
    .cnt_i    (cnt_o),
    .ra_rd_i  (ra_rd_i),
    .rb_rd_i  (rb_rd_i),
    .ra_o     (ra_o),
    .rb_o     (rb_o),
    .ra_ld_o  (ra_ld_w),
    .rb_ld_o  (rb_ld_w),
    .lovr_o   (lovr_w)
  );

  always_comb begin
    ev_w          = '0;
    ev_w[FL_OVF]  = ovf_w;
    ev_w[FL_LOVR] = lovr_w;
    ev_w[FL_CPC]  = cpc_w;
    ev_w[FL_LDA]  = ra_ld_w;
    ev_w[FL_LDB]  = rb_ld_w;
    ev_w[FL_ETRG] = ext_trg_w;
  end

  cap_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev_w),
    .sr_rd_i    (sr_rd_i),
    .int_en_i   (int_en_i),
    .int_dis_i  (int_dis_i),
    .int_bits_i (int_bits_i),
    .status_o   (status_o),
    .imr_o      (imr_o),
    .irq_o      (irq_o)
  );

  assign mir_a_o = lvl_w[PIN_A];
  assign mir_b_o = lvl_w[PIN_B];
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sw_trg_i,
  input logic             clk_dis_i,
  input logic             sr_rd_i,
  input logic             int_dis_i,
  input logic [7:0]       int_bits_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] ra_o,
  input logic [CNT_W-1:0] rb_o,
  input logic [7:0]       status_o,
  input logic             clk_sta_o,
  input logic [7:0]       imr_o,
  input logic             irq_o,
  input logic             run_w,
  input logic             ra_ld_w,
  input logic             rb_ld_w
);
  AST_CLK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_dis_i |=> !clk_sta_o); // R2
  AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_w && cnt_o == {CNT_W{1'b1}}) |=> (cnt_o == '0 && status_o[0])); // R3
  AST_SW_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_trg_i |=> cnt_o == '0); // R5
  AST_RA_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_ld_w |=> (ra_o == $past(cnt_o) && status_o[5])); // R6
  AST_RB_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_ld_w |=> (rb_o == $past(cnt_o) && status_o[6])); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !sr_rd_i) |=> status_o[0]); // R10
  AST_MASK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_dis_i |=> (imr_o & $past(int_bits_i)) == 8'h00); // R11
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imr_o == 8'h00) |-> !irq_o); // R11
endmodule

bind cap_timer_ch cap_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sw_trg_i   (sw_trg_i),
  .clk_dis_i  (clk_dis_i),
  .sr_rd_i    (sr_rd_i),
  .int_dis_i  (int_dis_i),
  .int_bits_i (int_bits_i),
  .cnt_o      (cnt_o),
  .ra_o       (ra_o),
  .rb_o       (rb_o),
  .status_o   (status_o),
  .clk_sta_o  (clk_sta_o),
  .imr_o      (imr_o),
  .irq_o      (irq_o),
  .run_w      (run_w),
  .ra_ld_w    (ra_ld_w),
  .rb_ld_w    (rb_ld_w)
);

// File: tb/cap_timer_ch_tb.sv
`timescale 1ns/1ps
module cap_timer_ch_tb_top;
  localparam int W = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cnt_en_i, clk_en_i, clk_dis_i, sw_trg_i, tin_a_i, tin_b_i;
  logic [1:0] ra_edge_i, rb_edge_i, trg_edge_i;
  logic trg_src_a_i, rc_trg_en_i, stop_on_rb_i, dis_on_rb_i;
  logic [W-1:0] rc_val_i;
  logic ra_rd_i, rb_rd_i, sr_rd_i, int_en_i, int_dis_i;
  logic [7:0] int_bits_i;
  logic [W-1:0] cnt_o, ra_o, rb_o;
  logic [7:0] status_o, imr_o;
  logic clk_sta_o, mir_a_o, mir_b_o, irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [W-1:0] m_cnt, m_ra, m_rb;
  logic [7:0]   m_sts, m_imr;
  logic m_on, m_halt, m_wantb, m_raun, m_rbun, m_aq, m_bq;

  always #10 clk_i = ~clk_i;

  cap_timer_ch #(.CNT_W(W)) dut_i (.*);

  function automatic logic ehit(input logic [1:0] s, input logic r, input logic f);
    return (s == 2'b01) ? r : (s == 2'b10) ? f : (s == 2'b11) ? (r | f) : 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_ra = '0; m_rb = '0; m_sts = '0; m_imr = '0;
    m_on = 0; m_halt = 0; m_wantb = 0; m_raun = 0; m_rbun = 0; m_aq = 0; m_bq = 0;
  endtask

  task automatic model_tick();
    logic ar, af, br, bf, tr, tf, run, cpc, ovf, ext, rst_c, lda, ldb, lov;
    logic [7:0] ev, setm, clrm;
    ar = tin_a_i & ~m_aq;  af = ~tin_a_i & m_aq;
    br = tin_b_i & ~m_bq;  bf = ~tin_b_i & m_bq;
    tr = trg_src_a_i ? ar : br;
    tf = trg_src_a_i ? af : bf;
    ext = ehit(trg_edge_i, tr, tf);
    run = m_on & ~m_halt & cnt_en_i;
    cpc = run && (m_cnt == rc_val_i);
    ovf = run && (m_cnt == 16'hFFFF);
    rst_c = ext | sw_trg_i | (cpc & rc_trg_en_i);
    lda = ehit(ra_edge_i, ar, af) & ~m_wantb;
    ldb = ehit(rb_edge_i, ar, af) & m_wantb;
    lov = (lda & m_raun) | (ldb & m_rbun);
    ev = {ext, ldb, lda, cpc, 2'b00, lov, ovf};
    m_sts = (sr_rd_i ? 8'h00 : m_sts) | ev;
    setm = int_en_i ? int_bits_i : 8'h00;
    clrm = int_dis_i ? int_bits_i : 8'h00;
    m_imr = (m_imr | setm) & ~clrm;
    if (lda) begin m_ra = m_cnt; m_raun = 1; m_wantb = 1; end
    else if (ra_rd_i) m_raun = 0;
    if (ldb) begin m_rb = m_cnt; m_rbun = 1; m_wantb = 0; end
    else if (rb_rd_i) m_rbun = 0;
    if (ldb && stop_on_rb_i) m_halt = 1;
    else if (rst_c) m_halt = 0;
    if (clk_dis_i || (ldb && dis_on_rb_i)) m_on = 0;
    else if (clk_en_i) m_on = 1;
    if (rst_c) m_cnt = '0;
    else if (run) m_cnt = m_cnt + 1'b1;
    m_aq = tin_a_i; m_bq = tin_b_i;
  endtask

  task automatic cmp_all();
    chk("R2 cnt", cnt_o, m_cnt);
    chk("R2 clk_sta", clk_sta_o, m_on);
    chk("R6 ra", ra_o, m_ra);
    chk("R7 rb", rb_o, m_rb);
    chk("R10 status", status_o, m_sts);
    chk("R11 imr", imr_o, m_imr);
    chk("R11 irq", irq_o, |(m_sts & m_imr));
    chk("R12 mirror", {mir_b_o, mir_a_o}, {m_bq, m_aq});
  endtask

  // called at a falling edge with inputs set; returns at the next falling edge
  task automatic cyc();
    @(posedge clk_i);
    #1 model_tick();
    @(negedge clk_i);
    cmp_all();
    clk_en_i = 0; clk_dis_i = 0; sw_trg_i = 0;
    ra_rd_i = 0; rb_rd_i = 0; sr_rd_i = 0; int_en_i = 0; int_dis_i = 0;
  endtask

  task automatic cycn(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    cnt_en_i = 0; clk_en_i = 0; clk_dis_i = 0; sw_trg_i = 0; tin_a_i = 0; tin_b_i = 0;
    ra_edge_i = 0; rb_edge_i = 0; trg_edge_i = 0; trg_src_a_i = 0; rc_trg_en_i = 0;
    stop_on_rb_i = 0; dis_on_rb_i = 0; rc_val_i = 16'hFFF0;
    ra_rd_i = 0; rb_rd_i = 0; sr_rd_i = 0; int_en_i = 0; int_dis_i = 0; int_bits_i = 0;
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 cnt", cnt_o, 0); chk("R1 ra", ra_o, 0); chk("R1 rb", rb_o, 0);
    chk("R1 status", status_o, 0); chk("R1 imr", imr_o, 0);
    chk("R1 irq", irq_o, 0); chk("R1 clk_sta", clk_sta_o, 0);
    rst_ni = 1;

    // R2 counting after enable and restart
    ra_edge_i = 2'b01; rb_edge_i = 2'b10; stop_on_rb_i = 1; cnt_en_i = 1;
    clk_en_i = 1; cyc();
    sw_trg_i = 1; cyc();
    cycn(5);
    chk("R2 count after 5", cnt_o, 5);
    // R6 A capture on rising A
    tin_a_i = 1; cyc();
    chk("R6 ra value", ra_o, 5);
    chk("R6 flag5", status_o[5], 1);
    cycn(2);
    // R7 B capture on falling A, R9 halt
    tin_a_i = 0; cyc();
    chk("R7 rb value", rb_o, 8);
    chk("R7 flag6", status_o[6], 1);
    cycn(3);
    chk("R9 halted", cnt_o, 9);
    // R8 overrun: A captured again without a read
    tin_a_i = 1; cyc();
    chk("R8 overrun flag", status_o[1], 1);
    chk("R8 ra reload", ra_o, 9);
    // R10 read clears flags
    sr_rd_i = 1; cyc();
    chk("R10 cleared", status_o, 0);
    // R11 mask on B capture flag
    int_bits_i = 8'h40; int_en_i = 1; cyc();
    tin_a_i = 0; cyc();
    chk("R11 irq on", irq_o, 1);
    int_dis_i = 1; cyc();
    chk("R11 irq off", irq_o, 0);
    // R12 mirror
    tin_b_i = 1; cyc();
    chk("R12 mir_b", mir_b_o, 1);
    tin_b_i = 0; cyc();
    // R5 restart on rising B clears halt
    trg_edge_i = 2'b01; tin_b_i = 1; cyc();
    chk("R5 restart cnt", cnt_o, 0);
    chk("R5 flag7", status_o[7], 1);
    cyc();
    chk("R5 runs again", cnt_o, 1);
    // R4 compare restart
    stop_on_rb_i = 0; ra_edge_i = 0; rb_edge_i = 0; trg_edge_i = 0;
    rc_val_i = 16'd3; rc_trg_en_i = 1; sr_rd_i = 1; sw_trg_i = 1; cyc();
    cycn(4);
    chk("R4 cmp restart", cnt_o, 0);
    chk("R4 flag4", status_o[4], 1);
    // R3 wrap
    rc_trg_en_i = 0; rc_val_i = 16'hFF00; sw_trg_i = 1; cyc();
    sr_rd_i = 1; cyc();
    cycn(65534);
    chk("R3 at max", cnt_o, 16'hFFFF);
    chk("R3 no flag yet", status_o[0], 0);
    cyc();
    chk("R3 wrapped", cnt_o, 0);
    chk("R3 flag0", status_o[0], 1);
    // R9 clock off on B capture
    ra_edge_i = 2'b01; rb_edge_i = 2'b01; dis_on_rb_i = 1;
    tin_a_i = 1; cyc(); tin_a_i = 0; cyc(); tin_a_i = 1; cyc();
    chk("R9 clock off", clk_sta_o, 0);
    dis_on_rb_i = 0; tin_a_i = 0; cyc();

    // random phases
    for (int p = 0; p < 20; p++) begin
      ra_edge_i = 2'($urandom); rb_edge_i = 2'($urandom); trg_edge_i = 2'($urandom);
      trg_src_a_i = 1'($urandom); rc_trg_en_i = 1'($urandom);
      stop_on_rb_i = 1'($urandom); dis_on_rb_i = ($urandom % 4) == 0;
      rc_val_i = ($urandom % 3 == 0) ? 16'hFFFF - 16'($urandom % 64) : 16'($urandom % 200);
      for (int i = 0; i < 300; i++) begin
        cnt_en_i   = ($urandom % 8) != 0;
        clk_en_i   = ($urandom % 20) == 0;
        clk_dis_i  = ($urandom % 80) == 0;
        sw_trg_i   = ($urandom % 60) == 0;
        if ($urandom % 8 == 0) tin_a_i = ~tin_a_i;
        if ($urandom % 12 == 0) tin_b_i = ~tin_b_i;
        ra_rd_i    = ($urandom % 4) == 0;
        rb_rd_i    = ($urandom % 4) == 0;
        sr_rd_i    = ($urandom % 5) == 0;
        int_en_i   = ($urandom % 25) == 0;
        int_dis_i  = ($urandom % 30) == 0;
        int_bits_i = 8'($urandom);
        cyc();
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule